// File: doc/BRIEF.md
# Sync Field Transmit Serializer

This block turns a programmed synchronization pattern into the serial sync field of an outgoing packet, sent right after the preamble. The pattern sits in three byte inputs. Byte 0 is the most significant. The field goes out most significant bit first, one bit for each bit-ready strobe from the modulator side.

The matching length may be any value from 1 to 24 bits, but the transmitted field is always rounded up to a whole number of bytes. Bit positions the length does not cover come first in the field. They are filled with the alternating preamble pattern, which carries on from the preamble without repeating a bit. The significant sync bits therefore close the field. The caller pulses start after the preamble, answers each strobe with the presented bit, and uses the done pulse to move on to the payload.

Top module: `sync_tx_serializer`

## Requirements
- R1: After reset the block is idle, and bit-ready strobes raise neither tx_vld nor tx_done until a start pulse is accepted.
- R2: Bits are sent most significant bit first, starting with sync_b0, then sync_b1, then sync_b2; with a length of 24 the field is exactly {sync_b0, sync_b1, sync_b2}.
- R3: The field is 8 bits for an effective length of 1 to 8, 16 bits for 9 to 16, and 24 bits for 17 to 24.
- R4: With N field bytes and effective length L, the first 8N-L bits sent are pad bits, alternating 0,1,0,1,... and starting with 0. The remaining L bits are the last L bits of {sync_b0..sync_b(N-1)}, in the same order.
- R5: While a field is in progress, tx_vld equals bit_rdy, and tx_bit carries the next field bit in that same cycle; a cycle without a strobe neither sends nor skips a bit.
- R6: tx_done is high in exactly one cycle per field: the strobe cycle that carries the final bit.
- R7: A start pulse that arrives while a field is in progress is ignored, and the field in progress continues unchanged.
- R8: A length input of 0 acts as 1, and a length above 24 acts as 24.
- R9: The pattern bytes and the length are sampled in the cycle that start is accepted; later changes to them do not affect the field in progress.
- R10: After the final bit, strobes produce no tx_vld until the next start; a start in the cycle after tx_done is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin sending a sync field (used only while idle) |
| bit_rdy | input | 1 | Strobe: consumer takes one bit this cycle |
| sync_b0 | input | 8 | Pattern byte 0 (sent first) |
| sync_b1 | input | 8 | Pattern byte 1 |
| sync_b2 | input | 8 | Pattern byte 2 |
| sync_len | input | 5 | Matching length in bits |
| tx_bit | output | 1 | Current serial bit |
| tx_vld | output | 1 | tx_bit is taken this cycle |
| tx_done | output | 1 | This strobe carries the final bit |

## Verification
A wrong remaining-bit count shows at the ports as a field of the wrong length. tx_done then lands on the wrong strobe, or extra tx_vld cycles appear after the field, and this is visible on the last strobe of the first field sent. A wrong pad count or wrong pad phase flips a bit in the first byte of the field on the strobe where it occurs. A shift register that moves without a strobe, or reloads on a second start, drops or repeats bits from the next strobe onward. The bench compares every transmitted bit against a model built from the requirements, so each of these faults is reported within the field in which it occurs.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 3;
    localparam int FIELD_W   = BYTE_W * NUM_BYTES;
    localparam int LEN_W     = 5;
    localparam int CNT_W     = $clog2(FIELD_W + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] pad;
    } field_plan_t;

    // Effective length: zero becomes one, anything above the field becomes the field.
    function automatic int eff_len(input int raw);
        if (raw < 1)
            return 1;
        else if (raw > FIELD_W)
            return FIELD_W;
        return raw;
    endfunction

    function automatic field_plan_t plan_field(input int raw);
        field_plan_t p;
        int el;
        int nb;
        el      = eff_len(raw);
        nb      = (el + BYTE_W - 1) / BYTE_W;
        p.total = CNT_W'(nb * BYTE_W);
        p.pad   = CNT_W'(nb * BYTE_W - el);
        return p;
    endfunction

endpackage

// File: rtl/sync_tx_plan.sv
module sync_tx_plan
    import sync_tx_pkg::*;
(
    input  logic [LEN_W-1:0] len_i,
    output field_plan_t      plan_o
);

    always_comb begin
        plan_o = plan_field(int'(len_i));
    end

endmodule

// File: rtl/sync_tx_frame.sv
module sync_tx_frame
    import sync_tx_pkg::*;
(
    input  logic [FIELD_W-1:0] word_i,
    input  field_plan_t        plan_i,
    output logic [FIELD_W-1:0] frame_o
);

    // Position k is the k-th bit sent; frame_o is left aligned.
    for (genvar k = 0; k < FIELD_W; k++) begin : g_pos
        localparam logic PAD_VAL = 1'((k % 2) != 0);
        assign frame_o[FIELD_W-1-k] =
            (CNT_W'(k) < plan_i.pad) ? PAD_VAL : word_i[FIELD_W-1-k];
    end

endmodule

// File: rtl/sync_tx_shift.sv
module sync_tx_shift
    import sync_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               bit_rdy,
    input  logic [FIELD_W-1:0] frame_i,
    input  field_plan_t        plan_i,
    output logic               tx_bit,
    output logic               tx_vld,
    output logic               tx_done
);

    tx_state_e          state;
    logic [FIELD_W-1:0] shreg;
    logic [CNT_W-1:0]   rem;
    logic               last;

    assign last    = (rem == CNT_W'(1));
    assign tx_bit  = shreg[FIELD_W-1];
    assign tx_vld  = (state == ST_SEND) && bit_rdy;
    assign tx_done = tx_vld && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            shreg <= '0;
            rem   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SEND;
                        shreg <= frame_i;
                        rem   <= plan_i.total;
                    end
                end
                ST_SEND: begin
                    if (bit_rdy) begin
                        shreg <= {shreg[FIELD_W-2:0], 1'b0};
                        rem   <= rem - CNT_W'(1);
                        if (last)
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_rem_range_R3: assert property (@(posedge clk) disable iff (rst)
        rem <= CNT_W'(FIELD_W));

    assert_send_has_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND) |-> (rem != '0));

    assert_no_move_without_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && !bit_rdy) |=> ($stable(shreg) && $stable(rem)));

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> (state == ST_IDLE));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND && start) |=>
            (rem == $past(rem) - CNT_W'($past(bit_rdy))));

endmodule

// File: rtl/sync_tx_serializer.sv
module sync_tx_serializer
    import sync_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              bit_rdy,
    input  logic [BYTE_W-1:0] sync_b0,
    input  logic [BYTE_W-1:0] sync_b1,
    input  logic [BYTE_W-1:0] sync_b2,
    input  logic [LEN_W-1:0]  sync_len,
    output logic              tx_bit,
    output logic              tx_vld,
    output logic              tx_done
);

    logic [BYTE_W-1:0]  pat [NUM_BYTES];
    logic [FIELD_W-1:0] word;
    logic [FIELD_W-1:0] frame;
    field_plan_t        plan;

    assign pat[0] = sync_b0;
    assign pat[1] = sync_b1;
    assign pat[2] = sync_b2;

    // Byte 0 occupies the top of the word, so it leaves first.
    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_pack
        assign word[FIELD_W-1-b*BYTE_W -: BYTE_W] = pat[b];
    end

    sync_tx_plan u_plan (
        .len_i  (sync_len),
        .plan_o (plan)
    );

    sync_tx_frame u_frame (
        .word_i  (word),
        .plan_i  (plan),
        .frame_o (frame)
    );

    sync_tx_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bit_rdy (bit_rdy),
        .frame_i (frame),
        .plan_i  (plan),
        .tx_bit  (tx_bit),
        .tx_vld  (tx_vld),
        .tx_done (tx_done)
    );

endmodule

// File: tb/sim_sync_tx_serializer.sv
module sim_sync_tx_serializer;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       bit_rdy = 1'b0;
    logic [7:0] sync_b0 = '0;
    logic [7:0] sync_b1 = '0;
    logic [7:0] sync_b2 = '0;
    logic [4:0] sync_len = '0;
    logic       tx_bit;
    logic       tx_vld;
    logic       tx_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    sync_tx_serializer u0 (
        .clk(clk), .rst(rst), .start(start), .bit_rdy(bit_rdy),
        .sync_b0(sync_b0), .sync_b1(sync_b1), .sync_b2(sync_b2),
        .sync_len(sync_len), .tx_bit(tx_bit), .tx_vld(tx_vld), .tx_done(tx_done)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    function automatic int model_len(input int raw);
        if (raw == 0) return 1;
        if (raw > 24) return 24;
        return raw;
    endfunction

    function automatic int model_total(input int raw);
        int l;
        l = model_len(raw);
        if (l <= 8) return 8;
        if (l <= 16) return 16;
        return 24;
    endfunction

    function automatic logic model_bit(input logic [7:0] b0, input logic [7:0] b1,
                                       input logic [7:0] b2, input int raw, input int k);
        logic [23:0] w;
        int tot;
        int pad;
        w   = {b0, b1, b2};
        tot = model_total(raw);
        pad = tot - model_len(raw);
        if (k < pad) return logic'(k % 2);
        return w[23-k];
    endfunction

    // Send one full field and compare each bit against the model.
    // stall: insert an idle cycle before every odd bit.
    // restart: pulse start again at bit 3 with different values.
    // scramble: change pattern and length right after start.
    task automatic send_field(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input int raw,
                              input bit stall, input bit restart, input bit scramble);
        int tot;
        int seen_done;
        tot = model_total(raw);
        seen_done = 0;
        @(negedge clk);
        sync_b0 = b0; sync_b1 = b1; sync_b2 = b2; sync_len = 5'(raw);
        start = 1'b1; bit_rdy = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            sync_b0 = ~b0; sync_b1 = ~b1; sync_b2 = ~b2; sync_len = 5'(raw ^ 5'h0F);
        end
        for (int k = 0; k < tot; k++) begin
            if (stall && (k % 2 == 1)) begin
                bit_rdy = 1'b0;
                #1;
                check({tag, " R5 no vld without strobe"}, int'(tx_vld), 0);
                @(negedge clk);
            end
            bit_rdy = 1'b1;
            start = restart && (k == 3);
            if (restart && k == 3) begin
                sync_b0 = 8'h00; sync_len = 5'd3;
            end
            #1;
            check({tag, " R5 vld on strobe"}, int'(tx_vld), 1);
            check({tag, " R2 R4 bit value"}, int'(tx_bit), int'(model_bit(b0, b1, b2, raw, k)));
            check({tag, " R6 done position"}, int'(tx_done), (k == tot - 1) ? 1 : 0);
            if (tx_done) seen_done++;
            @(negedge clk);
            start = 1'b0;
        end
        check({tag, " R3 R6 one done per field"}, seen_done, 1);
        bit_rdy = 1'b1;
        #1;
        check({tag, " R10 no vld after field"}, int'(tx_vld), 0);
        check({tag, " R10 no done after field"}, int'(tx_done), 0);
        @(negedge clk);
        bit_rdy = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bit_rdy = 1'b1;
            #1;
            check("R1 vld low after reset", int'(tx_vld), 0);
            check("R1 done low after reset", int'(tx_done), 0);
            @(negedge clk);
        end
        bit_rdy = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        test_reset();
        send_field("full24",  8'hA5, 8'h3C, 8'hF0, 24, 0, 0, 0);   // R2, R3
        send_field("len12",   8'h96, 8'hE1, 8'h00, 12, 1, 0, 0);   // R4, R5
        send_field("len5",    8'hFF, 8'h00, 8'h00, 5,  0, 0, 0);   // R4
        send_field("len8",    8'h5A, 8'h00, 8'h00, 8,  0, 0, 0);   // R3
        send_field("len9",    8'hC3, 8'h81, 8'h00, 9,  0, 0, 0);   // R3
        send_field("len16",   8'h12, 8'h34, 8'h00, 16, 0, 0, 0);   // R3
        send_field("len17",   8'hFF, 8'hFF, 8'hFF, 17, 1, 0, 0);   // R3, R4
        send_field("len0",    8'hFF, 8'h00, 8'h00, 0,  0, 0, 0);   // R8
        send_field("len31",   8'hDE, 8'hAD, 8'hBE, 31, 0, 0, 0);   // R8
        send_field("restart", 8'h0F, 8'hF0, 8'h55, 20, 0, 1, 0);   // R7
        send_field("sampled", 8'hB7, 8'h29, 8'h00, 14, 1, 0, 1);   // R9
        send_field("b2b",     8'h01, 8'h80, 8'h00, 1,  0, 0, 0);   // R10 after previous
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule